// File: doc/BRIEF.md
# Counter-Addressed Video Fetch Interleaver

This block feeds a pixel stream from a parallel byte-wide video SRAM without any help from the display controller. A nibble counter runs through every colour clock of the frame, including the blanking intervals. Software clears it with a frame sync strobe once per frame. The byte address is the counter divided by two. Each fetched byte yields two 4-bit pixels, high nibble first. Blank regions of the picture are simply bytes that hold zero.

The SRAM is time-shared with the CPU on every bus cycle. The colour clock runs at twice the bus rate, so the bus phase input alternates on successive colour clocks. While the phase is low, the block drives the counter address and reads video data. While it is high, the CPU address reaches the SRAM and the CPU can read or write. The block drives the data bus only for a CPU write and releases it at all other times. After a full frame of nibbles has been fetched, the counter parks at its terminal count and the block emits zero pixels until the next sync.

Top module: `vfetch_interleaver`

## Requirements
- R1: After reset `pixel` is 0. The counter is parked at its terminal count, so no fetch occurs until the first `frame_sync`. During a low phase, `sram_addr` then equals CLKS_PER_LINE*LINES_PER_FRAME/2.
- R2: While `bus_phase` is 0, `sram_addr` equals the nibble counter shifted right by one. In this phase `sram_oe_n` is 0, `sram_we_n` is 1, and the block does not drive `sram_dq`.
- R3: While `bus_phase` is 1 and `cpu_we` is 1, `sram_addr` equals `cpu_addr` and `sram_we_n` is 0. `sram_oe_n` is 1, and `sram_dq` carries `cpu_wdata`. The SRAM stores the byte at the clock edge that ends the cycle.
- R4: While `bus_phase` is 1 and `cpu_we` is 0, `sram_addr` equals `cpu_addr`. `sram_oe_n` is 0, `sram_we_n` is 1, and `cpu_rdata` shows the SRAM byte at that address.
- R5: At a clock edge with an even counter value, the byte on `sram_dq` is captured and its bits [7:4] appear on `pixel` in the following cycle. At the next edge, which has an odd counter value, bits [3:0] of that byte appear.
- R6: The counter advances by one on every colour clock, so the video byte address advances once per two colour clocks.
- R7: A `frame_sync` high at a clock edge sets the counter to 0 and `pixel` to 0 for the following cycle. Software issues it during a high phase, so that nibble 0 is fetched in the next low phase.
- R8: Once CLKS_PER_LINE*LINES_PER_FRAME nibbles have been fetched, the counter holds its terminal count. The address then stays at the terminal byte address and `pixel` stays 0 until the next `frame_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phase | input | 1 | Bus clock phase: 0 video slot, 1 CPU slot |
| frame_sync | input | 1 | Software frame sync, clears the counter |
| cpu_addr | input | ADDR_W | CPU byte address into the SRAM |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_we | input | 1 | CPU write enable, active high |
| cpu_rdata | output | DATA_W | CPU read data from the SRAM bus |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq | inout | DATA_W | SRAM bidirectional data bus |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| pixel | output | 4 | Pixel nibble for the current colour clock |

## Verification
The bench builds the block with 12 colour clocks per line, 4 lines per frame and a 6-bit address. A whole frame is then 48 nibbles in 24 bytes. That size lets the run reach the terminal count, stay parked there, and take a mid-frame sync within a few hundred cycles. The address range is wide enough for CPU writes to land both inside the video region and outside it. A write inside the region changes pixels later in the same frame, and those pixels are checked against the written value.

// File: rtl/vfi_pkg.sv
package vfi_pkg;
    typedef enum logic {
        SLOT_VIDEO = 1'b0,
        SLOT_CPU   = 1'b1
    } slot_e;

    function automatic slot_e slot_of(input logic phase);
        return phase ? SLOT_CPU : SLOT_VIDEO;
    endfunction
endpackage

// File: rtl/vfi_nibble_counter.sv
module vfi_nibble_counter #(
    parameter int TOTAL = 59736,
    parameter int CNT_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    localparam logic [CNT_W-1:0] TERM = CNT_W'(TOTAL);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != TERM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= TERM;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign active = (st_q.cnt != TERM);
endmodule

// File: rtl/vfi_bus_arbiter.sv
module vfi_bus_arbiter
    import vfi_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              bus_phase,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              drive_en
);
    always_comb begin
        mem_addr = fetch_addr;
        mem_oe_n = 1'b0;
        mem_we_n = 1'b1;
        drive_en = 1'b0;
        if (slot_of(bus_phase) == SLOT_CPU) begin
            mem_addr = cpu_addr;
            if (cpu_we) begin
                mem_oe_n = 1'b1;
                mem_we_n = 1'b0;
                drive_en = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vfi_pixel_unpack.sv
module vfi_pixel_unpack #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              active,
    input  logic              even,
    input  logic [DATA_W-1:0] fetch_byte,
    output logic [3:0]        pixel
);
    typedef struct packed {
        logic [3:0] low_nib;
        logic [3:0] pix;
    } unpack_state_t;

    unpack_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync || !active) begin
            st_d.pix = 4'h0;
        end else if (even) begin
            st_d.pix     = fetch_byte[7:4];
            st_d.low_nib = fetch_byte[3:0];
        end else begin
            st_d.pix = st_q.low_nib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pixel = st_q.pix;
endmodule

// File: rtl/vfetch_interleaver.sv
module vfetch_interleaver #(
    parameter int CLKS_PER_LINE   = 228,
    parameter int LINES_PER_FRAME = 262,
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phase,
    input  logic              frame_sync,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [3:0]        pixel
);
    localparam int TOTAL = CLKS_PER_LINE * LINES_PER_FRAME;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic              drive_en;
    logic [ADDR_W-1:0] fetch_addr;

    vfi_nibble_counter #(.TOTAL(TOTAL), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync   (frame_sync),
        .cnt    (cnt),
        .active (active)
    );

    assign fetch_addr = ADDR_W'(cnt >> 1);

    vfi_bus_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .bus_phase  (bus_phase),
        .fetch_addr (fetch_addr),
        .cpu_addr   (cpu_addr),
        .cpu_we     (cpu_we),
        .mem_addr   (sram_addr),
        .mem_oe_n   (sram_oe_n),
        .mem_we_n   (sram_we_n),
        .drive_en   (drive_en)
    );

    assign sram_dq   = drive_en ? cpu_wdata : {DATA_W{1'bz}};
    assign cpu_rdata = sram_dq;

    vfi_pixel_unpack #(.DATA_W(DATA_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync       (frame_sync),
        .active     (active),
        .even       (~cnt[0]),
        .fetch_byte (sram_dq),
        .pixel      (pixel)
    );
endmodule

// File: rtl/vfi_checker.sv
module vfi_checker #(
    parameter int CLKS_PER_LINE   = 228,
    parameter int LINES_PER_FRAME = 262,
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_phase,
    input logic              frame_sync,
    input logic              cpu_we,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [3:0]        pixel
);
    localparam logic [ADDR_W-1:0] TERM_ADDR =
        ADDR_W'((CLKS_PER_LINE * LINES_PER_FRAME) / 2);

    assert_video_slot_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_phase |-> (!sram_oe_n && sram_we_n));

    assert_cpu_write_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase && cpu_we) |-> (!sram_we_n && sram_oe_n && sram_dq == cpu_wdata));

    assert_no_bus_fight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !bus_phase && !frame_sync && sram_addr != TERM_ADDR)
        ##1 (rst_n && !frame_sync)
        ##1 (rst_n && !bus_phase && !frame_sync)
        |-> sram_addr == ADDR_W'($past(sram_addr, 2) + 1'b1));

    assert_sync_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> pixel == 4'h0);

    assert_park_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !bus_phase && !frame_sync && sram_addr == TERM_ADDR) |=> pixel == 4'h0);

    assert_park_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !bus_phase && !frame_sync && sram_addr == TERM_ADDR)
        ##1 (rst_n && !frame_sync)
        ##1 (rst_n && !bus_phase)
        |-> sram_addr == TERM_ADDR);
endmodule

bind vfetch_interleaver vfi_checker #(
    .CLKS_PER_LINE   (CLKS_PER_LINE),
    .LINES_PER_FRAME (LINES_PER_FRAME),
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W)
) u_vfi_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_phase  (bus_phase),
    .frame_sync (frame_sync),
    .cpu_we     (cpu_we),
    .cpu_wdata  (cpu_wdata),
    .sram_addr  (sram_addr),
    .sram_dq    (sram_dq),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .pixel      (pixel)
);

// File: tb/vfetch_interleaver_bench.sv
module vfetch_interleaver_bench;
    localparam int CPL   = 12;
    localparam int LPF   = 4;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int TOTAL = CPL * LPF;
    localparam int MEMSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_phase = 1'b0;
    logic          frame_sync = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] sram_addr;
    wire  [DW-1:0] sram_dq;
    logic          sram_oe_n;
    logic          sram_we_n;
    logic [3:0]    pixel;

    always #5 clk = ~clk;

    vfetch_interleaver #(
        .CLKS_PER_LINE(CPL), .LINES_PER_FRAME(LPF), .ADDR_W(AW), .DATA_W(DW)
    ) u_vfetch_interleaver (
        .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .frame_sync(frame_sync),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_rdata(cpu_rdata), .sram_addr(sram_addr), .sram_dq(sram_dq),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .pixel(pixel)
    );

    // SRAM model driven only through the pins
    logic [DW-1:0] mem [MEMSZ];
    assign sram_dq = (!sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};
    always @(posedge clk) if (!sram_we_n) mem[sram_addr] <= sram_dq;

    // reference state
    int unsigned ref_mem [MEMSZ];
    int m_cnt  = TOTAL;
    int m_byte = 0;
    int m_pix  = 0;
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one colour clock: check pixel, drive inputs, check bus, advance model
    task automatic step(input bit fs, input bit we, input int addr, input int wd);
        @(negedge clk);
        check("R5 pixel", int'(pixel), m_pix);
        frame_sync = fs;
        cpu_we     = we;
        cpu_addr   = AW'(addr);
        cpu_wdata  = DW'(wd);
        #1;
        if (!bus_phase) begin
            check("R2 video addr", int'(sram_addr), m_cnt / 2);
            check("R2 oe_n", int'(sram_oe_n), 0);
            check("R2 we_n", int'(sram_we_n), 1);
        end else if (we) begin
            check("R3 addr", int'(sram_addr), addr);
            check("R3 we_n", int'(sram_we_n), 0);
            check("R3 oe_n", int'(sram_oe_n), 1);
            check("R3 data", int'(sram_dq), wd & 255);
        end else begin
            check("R4 addr", int'(sram_addr), addr);
            check("R4 rdata", int'(cpu_rdata), int'(ref_mem[addr]));
        end
        if (fs) begin
            m_cnt = 0;
            m_pix = 0;
        end else if (m_cnt < TOTAL) begin
            if (m_cnt % 2 == 0) begin
                m_byte = int'(ref_mem[m_cnt / 2]);
                m_pix  = m_byte >> 4;
            end else begin
                m_pix = m_byte & 15;
            end
            m_cnt++;
        end else begin
            m_pix = 0;
        end
        if (bus_phase && we) ref_mem[addr] = wd & 255;
        @(posedge clk);
        #1 bus_phase = ~bus_phase;
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin
            // bytes 20..23 zero: a blank stretch of the frame
            ref_mem[i] = (i >= 20 && i < 24) ? 0 : ((i * 37 + 5) & 255);
            mem[i]     = DW'(ref_mem[i]);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pixel", int'(pixel), 0);
        rst_n = 1'b1;
        bus_phase = 1'b0;
        // R1: parked before any sync
        for (int k = 0; k < 6; k++) step(0, 0, k, 0);
        check("R1 parked pixel", int'(pixel), 0);
        // R7: sync issued in a high phase
        step(0, 0, 40, 0);
        step(1, 0, 41, 0);
        // full frame with CPU traffic; R6 stepping, R8 park afterwards
        for (int k = 0; k < TOTAL + 10; k++) begin
            if (bus_phase) step(0, (k % 3) == 1, (k * 7 + 30) % MEMSZ, k * 13 + 1);
            else           step(0, 0, 0, 0);
        end
        check("R8 parked pixel", int'(pixel), 0);
        // CPU writes ahead of the fetch in a new frame (R3 effect on pixels)
        if (!bus_phase) step(0, 0, 0, 0);
        step(1, 1, 10, 8'hA5);
        for (int k = 0; k < 12; k++) begin
            if (bus_phase) step(0, 1, 12 + k, 8'h3C + k);
            else           step(0, 0, 0, 0);
        end
        // mid-frame resync (R7)
        if (!bus_phase) step(0, 0, 0, 0);
        step(1, 0, 12, 0);
        for (int k = 0; k < TOTAL + 6; k++) begin
            if (bus_phase) step(0, (k % 5) == 0, (k * 11) % MEMSZ, k * 29);
            else           step(0, 0, 0, 0);
        end
        step(0, 0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule